// File: doc/BRIEF.md
# SD Host Transfer Register Front End

This block is the register face of an SD/MMC host controller. Software writes the configuration words (bus enable and width, command index, argument, block geometry, buffer size, timing delays, timeout) through a flat 32-bit read/write port. A write to the control word with its start bit set and a legal transfer code launches one transfer: the block sends a single-cycle start pulse and the decoded transfer type to a separate command/data engine, and marks itself busy.

When the engine signals completion, the block leaves the busy state. It records the engine's error flags and the five response words, and sets a transfer-end flag. That flag is cleared by writing one to it. It drives the interrupt line only while its own enable bit is set. The line engines, DMA and clock generation sit outside this block.

Top module: `sdx_regs_top`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `eng_start` is 0.
- R2: Only defined bits are stored, and reserved bits read as zero. Enable word at 0x00: bits 1:0 select bus width (0 one line, 1 four lines, 2 eight lines), bit 2 double data rate, bit 7 controller on, bit 12 low-voltage signalling. Command at 0x0C: 6 bits. Argument at 0x10: 32 bits. Block size 0x2C, block count 0x30 and buffer size 0x34: 10 bits each. The data word at 0x28 and the response words read zero until a response is captured.
- R3: The control word is at 0x04. Its fields are: mode in bits 3:0, clock-on-last-block in bit 6, start in bit 7, init-clock count in 11:8, write delay in 19:16, read delay in 23:20, timeout count in 30:24 and timeout enable in bit 31. The legal modes are 0 (no response), 1 (short), 2 (136-bit), 3 (short with busy), 4 (read), 5 (write) and 8 (init clocks). A write with bit 7 set and a legal mode while idle makes `eng_start` high for exactly the one cycle after the write, with `eng_mode` equal to the written mode.
- R4: Control bit 7 reads 1 from the launch until the engine's `eng_done`. It reads 0 from the cycle after `eng_done`.
- R5: Any control write while a transfer is busy is ignored: no field changes and no start pulse.
- R6: A control write with bit 7 set and an illegal mode stores its fields, but it launches nothing.
- R7: A launching control write leaves the delay fields (bits 23:16) at their previous values.
- R8: `eng_done` while busy has these effects. It sets state bit 5 (transfer end). It latches `eng_err[0]` into state bit 0 (response CRC), `eng_err[1]` into bit 1 (read CRC), `eng_err[2]` into bit 2 (write CRC), `eng_err[3]` into bit 4 (no response) and `eng_err[4]` into bit 15 (timeout). It also captures `eng_rsp` word i into the read address 0x14+4*i.
- R9: `eng_done` while idle changes no state.
- R10: Writing 1 to state bit 5 clears it. A completion in the same cycle wins over the clear. State bit 6 is a read/write interrupt enable, and the error bits ignore writes.
- R11: `irq` is high exactly when state bits 5 and 6 are both set.
- R12: The latched error bits clear when the next transfer launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_start | output | 1 | One-cycle transfer launch pulse |
| eng_mode | output | 4 | Transfer type of the current transfer |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 5 | Engine error flags, valid with `eng_done` |
| eng_rsp | input | 160 | Five 32-bit response words, valid with `eng_done` |
| ctrl_word | output | 32 | Stored control word (start bit excluded) |
| en_word | output | 32 | Stored enable word |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| blk_size | output | 10 | Block size in bytes |
| blk_count | output | 10 | Number of blocks |
| buf_size | output | 10 | Buffer size in bytes |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The hardest case to reach is a completion that lands in the same cycle as a write-one-to-clear of the transfer-end flag. The bench sets up a transfer, then drives `eng_done` and the state write on the same falling edge, so that both are seen at one rising edge. A second hard case is a control write issued while busy. The bench sends a differing start command between launch and completion, then confirms that there is no pulse and that the readback is unchanged.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  localparam int DW = 32;

  localparam logic [7:0] OFF_EN    = 8'h00;
  localparam logic [7:0] OFF_CTRL  = 8'h04;
  localparam logic [7:0] OFF_STATE = 8'h08;
  localparam logic [7:0] OFF_CMD   = 8'h0C;
  localparam logic [7:0] OFF_ARG   = 8'h10;
  localparam logic [7:0] OFF_RSP0  = 8'h14;
  localparam logic [7:0] OFF_BSZ   = 8'h2C;
  localparam logic [7:0] OFF_BCNT  = 8'h30;
  localparam logic [7:0] OFF_BUFSZ = 8'h34;

  localparam logic [DW-1:0] EN_MASK   = 32'h0000_1087;
  localparam logic [DW-1:0] CTRL_MASK = 32'hFFFF_0F4F;

  localparam int CTRL_GO   = 7;
  localparam int DLY_LO    = 16;
  localparam int DLY_HI    = 23;

  localparam int ST_CRC7   = 0;
  localparam int ST_RCRC   = 1;
  localparam int ST_WCRC   = 2;
  localparam int ST_NORSP  = 4;
  localparam int ST_END    = 5;
  localparam int ST_ENDIE  = 6;
  localparam int ST_TOUT   = 15;

  localparam int ERR_N = 5;

  typedef enum logic [3:0] {
    XM_NORSP = 4'd0,
    XM_SHORT = 4'd1,
    XM_LONG  = 4'd2,
    XM_BUSY  = 4'd3,
    XM_READ  = 4'd4,
    XM_WRITE = 4'd5,
    XM_INIT  = 4'd8
  } xfer_mode_e;

  function automatic logic mode_legal(input logic [3:0] m);
    case (m)
      XM_NORSP, XM_SHORT, XM_LONG, XM_BUSY,
      XM_READ, XM_WRITE, XM_INIT: mode_legal = 1'b1;
      default:                    mode_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sdx_cfg_regs.sv
module sdx_cfg_regs
  import sdx_pkg::*;
#(
  parameter int CMD_W = 6,
  parameter int BLK_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             sel_en,
  input  logic             sel_cmd,
  input  logic             sel_arg,
  input  logic             sel_bsz,
  input  logic             sel_bcnt,
  input  logic             sel_bufsz,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    en_q,
  output logic [CMD_W-1:0] cmd_q,
  output logic [DW-1:0]    arg_q,
  output logic [BLK_W-1:0] bsz_q,
  output logic [BLK_W-1:0] bcnt_q,
  output logic [BLK_W-1:0] bufsz_q
);
  logic [DW-1:0]    en_d, arg_d;
  logic [CMD_W-1:0] cmd_d;
  logic [BLK_W-1:0] bsz_d, bcnt_d, bufsz_d;

  always_comb begin
    en_d    = en_q;
    cmd_d   = cmd_q;
    arg_d   = arg_q;
    bsz_d   = bsz_q;
    bcnt_d  = bcnt_q;
    bufsz_d = bufsz_q;
    if (wr && sel_en)    en_d    = wdata & EN_MASK;
    if (wr && sel_cmd)   cmd_d   = wdata[CMD_W-1:0];
    if (wr && sel_arg)   arg_d   = wdata;
    if (wr && sel_bsz)   bsz_d   = wdata[BLK_W-1:0];
    if (wr && sel_bcnt)  bcnt_d  = wdata[BLK_W-1:0];
    if (wr && sel_bufsz) bufsz_d = wdata[BLK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      cmd_q   <= '0;
      arg_q   <= '0;
      bsz_q   <= '0;
      bcnt_q  <= '0;
      bufsz_q <= '0;
    end else begin
      en_q    <= en_d;
      cmd_q   <= cmd_d;
      arg_q   <= arg_d;
      bsz_q   <= bsz_d;
      bcnt_q  <= bcnt_d;
      bufsz_q <= bufsz_d;
    end
  end

  // R2
  en_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~EN_MASK) == '0);
endmodule

// File: rtl/sdx_xfer_ctrl.sv
module sdx_xfer_ctrl
  import sdx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          eng_done,
  output logic [DW-1:0] ctrl_q,
  output logic          busy_q,
  output logic          launch,
  output logic          done_ev,
  output logic          start_q
);
  logic          wr_ok;
  logic [DW-1:0] ctrl_d;
  logic          busy_d;

  always_comb begin
    wr_ok   = wr_ctrl && !busy_q;
    launch  = wr_ok && wdata[CTRL_GO] && mode_legal(wdata[3:0]);
    done_ev = busy_q && eng_done;
    ctrl_d  = ctrl_q;
    if (wr_ok) begin
      ctrl_d = wdata & CTRL_MASK;
      if (launch) ctrl_d[DLY_HI:DLY_LO] = ctrl_q[DLY_HI:DLY_LO];
    end
    busy_d = busy_q;
    if (done_ev)     busy_d = 1'b0;
    else if (launch) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      busy_q  <= busy_d;
      start_q <= launch;
    end
  end

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && eng_done) |=> !busy_q);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && busy_q) |=> ($stable(ctrl_q) && !start_q));
  // R7
  delay_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> $stable(ctrl_q[DLY_HI:DLY_LO]));
endmodule

// File: rtl/sdx_status.sv
module sdx_status
  import sdx_pkg::*;
#(
  parameter int RSP_WORDS = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_state,
  input  logic                       w_end_clr,
  input  logic                       w_end_ie,
  input  logic                       launch,
  input  logic                       done_ev,
  input  logic [ERR_N-1:0]           eng_err,
  input  logic [RSP_WORDS*DW-1:0]    eng_rsp,
  output logic [DW-1:0]              state_rd,
  output logic [RSP_WORDS-1:0][DW-1:0] rsp_q,
  output logic                       irq
);
  logic             end_q, end_d, ie_q, ie_d;
  logic [ERR_N-1:0] err_q, err_d;

  always_comb begin
    end_d = end_q;
    if (done_ev)                     end_d = 1'b1;
    else if (wr_state && w_end_clr)  end_d = 1'b0;
    ie_d = wr_state ? w_end_ie : ie_q;
    err_d = err_q;
    if (done_ev)     err_d = eng_err;
    else if (launch) err_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= 1'b0;
      ie_q  <= 1'b0;
      err_q <= '0;
    end else begin
      end_q <= end_d;
      ie_q  <= ie_d;
      err_q <= err_d;
    end
  end

  for (genvar g = 0; g < RSP_WORDS; g++) begin : g_rsp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rsp_q[g] <= '0;
      else if (done_ev) rsp_q[g] <= eng_rsp[g*DW +: DW];
    end
  end

  always_comb begin
    state_rd           = '0;
    state_rd[ST_CRC7]  = err_q[0];
    state_rd[ST_RCRC]  = err_q[1];
    state_rd[ST_WCRC]  = err_q[2];
    state_rd[ST_NORSP] = err_q[3];
    state_rd[ST_TOUT]  = err_q[4];
    state_rd[ST_END]   = end_q;
    state_rd[ST_ENDIE] = ie_q;
  end

  assign irq = end_q & ie_q;

  // R8
  end_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> end_q);
  // R10
  end_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_state && w_end_clr && !done_ev) |=> !end_q);
  // R12
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (err_q == '0));
  // R8
  err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> (err_q == $past(eng_err)));
endmodule

// File: rtl/sdx_regs_top.sv
module sdx_regs_top
  import sdx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CMD_W     = 6,
  parameter int BLK_W     = 10,
  parameter int RSP_WORDS = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DW-1:0]           reg_wdata,
  output logic [DW-1:0]           reg_rdata,
  output logic                    eng_start,
  output logic [3:0]              eng_mode,
  input  logic                    eng_done,
  input  logic [ERR_N-1:0]        eng_err,
  input  logic [RSP_WORDS*DW-1:0] eng_rsp,
  output logic [DW-1:0]           ctrl_word,
  output logic [DW-1:0]           en_word,
  output logic [CMD_W-1:0]        cmd_idx,
  output logic [DW-1:0]           cmd_arg,
  output logic [BLK_W-1:0]        blk_size,
  output logic [BLK_W-1:0]        blk_count,
  output logic [BLK_W-1:0]        buf_size,
  output logic                    irq
);
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic sel_en, sel_ctrl, sel_state, sel_cmd, sel_arg, sel_bsz, sel_bcnt, sel_bufsz;
  always_comb begin
    sel_en    = reg_addr == ADDR_W'(OFF_EN);
    sel_ctrl  = reg_addr == ADDR_W'(OFF_CTRL);
    sel_state = reg_addr == ADDR_W'(OFF_STATE);
    sel_cmd   = reg_addr == ADDR_W'(OFF_CMD);
    sel_arg   = reg_addr == ADDR_W'(OFF_ARG);
    sel_bsz   = reg_addr == ADDR_W'(OFF_BSZ);
    sel_bcnt  = reg_addr == ADDR_W'(OFF_BCNT);
    sel_bufsz = reg_addr == ADDR_W'(OFF_BUFSZ);
  end

  logic [DW-1:0] ctrl_q, state_rd;
  logic          busy_q, launch, done_ev, start_q;
  logic [RSP_WORDS-1:0][DW-1:0] rsp_q;

  sdx_cfg_regs #(.CMD_W(CMD_W), .BLK_W(BLK_W)) u_cfg (
    .clk(clk), .rst_n(rst_s), .wr(reg_wr),
    .sel_en(sel_en), .sel_cmd(sel_cmd), .sel_arg(sel_arg),
    .sel_bsz(sel_bsz), .sel_bcnt(sel_bcnt), .sel_bufsz(sel_bufsz),
    .wdata(reg_wdata), .en_q(en_word), .cmd_q(cmd_idx), .arg_q(cmd_arg),
    .bsz_q(blk_size), .bcnt_q(blk_count), .bufsz_q(buf_size)
  );

  sdx_xfer_ctrl u_xfer (
    .clk(clk), .rst_n(rst_s), .wr_ctrl(reg_wr && sel_ctrl), .wdata(reg_wdata),
    .eng_done(eng_done), .ctrl_q(ctrl_q), .busy_q(busy_q), .launch(launch),
    .done_ev(done_ev), .start_q(start_q)
  );

  sdx_status #(.RSP_WORDS(RSP_WORDS)) u_stat (
    .clk(clk), .rst_n(rst_s), .wr_state(reg_wr && sel_state),
    .w_end_clr(reg_wdata[ST_END]), .w_end_ie(reg_wdata[ST_ENDIE]),
    .launch(launch), .done_ev(done_ev), .eng_err(eng_err), .eng_rsp(eng_rsp),
    .state_rd(state_rd), .rsp_q(rsp_q), .irq(irq)
  );

  assign eng_start = start_q;
  assign eng_mode  = ctrl_q[3:0];
  assign ctrl_word = ctrl_q;

  always_comb begin
    reg_rdata = '0;
    if (sel_en)    reg_rdata = en_word;
    if (sel_ctrl)  reg_rdata = ctrl_q | (DW'(busy_q) << CTRL_GO);
    if (sel_state) reg_rdata = state_rd;
    if (sel_cmd)   reg_rdata = DW'(cmd_idx);
    if (sel_arg)   reg_rdata = cmd_arg;
    if (sel_bsz)   reg_rdata = DW'(blk_size);
    if (sel_bcnt)  reg_rdata = DW'(blk_count);
    if (sel_bufsz) reg_rdata = DW'(buf_size);
    for (int i = 0; i < RSP_WORDS; i++) begin
      if (reg_addr == ADDR_W'(OFF_RSP0 + 8'(4 * i))) reg_rdata = rsp_q[i];
    end
  end

  // R11
  irq_end_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(irq) |-> state_rd[ST_END]);
endmodule

// File: tb/sim_sdx_regs_top.sv
module sim_sdx_regs_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr;
  logic [7:0]   reg_addr;
  logic [31:0]  reg_wdata, reg_rdata;
  logic         eng_start, eng_done, irq;
  logic [3:0]   eng_mode;
  logic [4:0]   eng_err;
  logic [159:0] eng_rsp;
  logic [31:0]  ctrl_word, en_word, cmd_arg;
  logic [5:0]   cmd_idx;
  logic [9:0]   blk_size, blk_count, buf_size;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdx_regs_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_mode(eng_mode), .eng_done(eng_done), .eng_err(eng_err),
    .eng_rsp(eng_rsp), .ctrl_word(ctrl_word), .en_word(en_word),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .blk_size(blk_size),
    .blk_count(blk_count), .buf_size(buf_size), .irq(irq)
  );

  // {addr, write data, expected readback}
  localparam logic [71:0] VEC [0:9] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h0000_1087},
    {8'h04, 32'hFFFF_FF7F, 32'hFFFF_0F4F},
    {8'h0C, 32'hFFFF_FFD1, 32'h0000_0011},
    {8'h10, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {8'h2C, 32'hFFFF_F200, 32'h0000_0200},
    {8'h30, 32'h0000_0C05, 32'h0000_0005},
    {8'h34, 32'h1234_5678, 32'h0000_0278},
    {8'h08, 32'hFFFF_FFDF, 32'h0000_0040},
    {8'h28, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h14, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic done_pulse(input logic [4:0] e);
    @(negedge clk);
    eng_done = 1'b1; eng_err = e;
    @(negedge clk);
    eng_done = 1'b0; eng_err = '0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    eng_done = 1'b0; eng_err = '0;
    for (int i = 0; i < 5; i++) eng_rsp[i*32 +: 32] = 32'h1000_0000 + 32'(i * 'h111);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a <= 'h34; a += 4) begin
      rd(8'(a), v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 eng_start", {31'b0, eng_start}, 32'h0);

    // R2 table of writes and masked readbacks
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk("R2 write/readback", v, VEC[i][31:0]);
    end

    // R7 setup: delays A5 with start clear
    wr(8'h04, 32'h00A5_0000);
    rd(8'h04, v);
    chk("R7 delay store", v, 32'h00A5_0000);

    // R3 launch a read transfer
    wr(8'h04, 32'h0000_0084);
    chk("R3 start pulse", {31'b0, eng_start}, 32'h1);
    chk("R3 mode", {28'b0, eng_mode}, 32'h4);
    @(negedge clk);
    chk("R3 pulse one cycle", {31'b0, eng_start}, 32'h0);
    rd(8'h04, v);
    chk("R4 R7 busy readback, delays kept", v, 32'h00A5_0084);

    // R5 write while busy
    wr(8'h04, 32'h0000_0081);
    chk("R5 no pulse while busy", {31'b0, eng_start}, 32'h0);
    rd(8'h04, v);
    chk("R5 ctrl unchanged", v, 32'h00A5_0084);

    // R8 completion with errors and response
    done_pulse(5'b10011);
    rd(8'h04, v);
    chk("R4 busy cleared", v, 32'h00A5_0004);
    rd(8'h08, v);
    chk("R8 state after done", v, 32'h0000_8063);
    chk("R11 irq set", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 5; i++) begin
      rd(8'(8'h14 + 4 * i), v);
      chk("R8 response word", v, 32'h1000_0000 + 32'(i * 'h111));
    end

    // R10 write one to clear, errors ignore writes
    wr(8'h08, 32'h0000_0060);
    rd(8'h08, v);
    chk("R10 end flag cleared", v, 32'h0000_8043);
    chk("R11 irq low", {31'b0, irq}, 32'h0);

    // R9 done while idle
    done_pulse(5'b01000);
    rd(8'h08, v);
    chk("R9 idle done ignored", v, 32'h0000_8043);

    // R12 errors clear on launch; init-clock mode
    wr(8'h04, 32'h0000_0588);
    chk("R3 mode 8", {28'b0, eng_mode}, 32'h8);
    rd(8'h08, v);
    chk("R12 errors cleared", v, 32'h0000_0040);

    // R11 interrupt masked
    wr(8'h08, 32'h0000_0000);
    done_pulse(5'b00000);
    rd(8'h08, v);
    chk("R11 end flag w/o enable", v, 32'h0000_0020);
    chk("R11 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h0000_0040);
    chk("R11 irq unmasked", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h0000_0060);

    // R6 illegal mode
    wr(8'h04, 32'h0000_0086);
    chk("R6 no pulse", {31'b0, eng_start}, 32'h0);
    rd(8'h04, v);
    chk("R6 fields stored, idle", v, 32'h0000_0006);

    // R10 completion and clear in the same cycle
    wr(8'h04, 32'h0000_0081);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h0000_0060;
    eng_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; eng_done = 1'b0;
    rd(8'h08, v);
    chk("R10 set wins over clear", v, 32'h0000_0060);

    finish_run();
  end
endmodule